// File: doc/BRIEF.md
# Per-Channel Digital Zero Suppressor

This block sits on a multi-channel stream of signed ADC samples and decides, once per event window, whether each channel's data is worth keeping. Every sample arrives with a channel index and a valid strobe. It is compared against a signed threshold that belongs to that channel. A per-channel direction bit selects the test: the sample must lie strictly above the threshold, or strictly below it. A per-channel polarity bit marks active-low inputs. For those inputs the sample is negated before the comparison, and the most negative code saturates to the most positive one.

A small controller has three states. IDLE waits for a window. The *open* transition (`win_start` in IDLE) enters COLLECT and clears every channel's sticky hit flag. COLLECT accepts samples, and the *close* transition (`win_end` in COLLECT) enters REPORT. A sample presented in the same cycle as `win_end` still counts. REPORT lasts exactly one cycle: `keep_valid` is high and `keep_flags` carries one decision bit per channel. The *retire* transition then returns unconditionally to IDLE. `win_start` is ignored outside IDLE, and `win_end` is ignored outside COLLECT.

While in COLLECT, samples of enabled channels are forwarded unchanged, one cycle later, on the output stream. A downstream buffer uses the keep flags to discard the data of suppressed channels. Global mode bits can switch all suppression off.

Top module: `dzs_filter`

## Requirements
- R1: While reset is held and after it is released, the block is in IDLE with `out_valid` and `keep_valid` low and `keep_flags` zero.
- R2: `win_start` in IDLE moves the block to COLLECT. `win_end` in COLLECT moves it to REPORT, so `keep_valid` is high in the cycle after `win_end`, for exactly one cycle, before the block returns to IDLE. `win_start` outside IDLE and `win_end` outside COLLECT have no effect.
- R3: A sample with `in_valid` high in COLLECT whose channel bit in `cfg_chan_en` is 1 appears one cycle later on `out_valid`/`out_chan`/`out_sample`, unchanged. Samples of disabled channels, and samples outside COLLECT, produce no output and set no flag.
- R4: A channel whose `cfg_chan_en` bit is 0 always reports keep flag 0.
- R5: When `cfg_mode` bit 0 is 1, suppression is bypassed and the keep flags equal `cfg_chan_en`.
- R6: When `cfg_mode` bit 2 is 0, digital suppression is off and the keep flags equal `cfg_chan_en`. Bit 1 has no effect.
- R7: A channel whose `cfg_zs_en` bit is 0 is not filtered: its keep flag equals its `cfg_chan_en` bit.
- R8: With `cfg_edge` bit 0, a sample qualifies only if it is strictly greater than the threshold. Equality does not qualify.
- R9: With `cfg_edge` bit 1, a sample qualifies only if it is strictly less than the threshold.
- R10: With `cfg_polarity` bit 1 (active-low), the sample is negated before the comparison, and the most negative code maps to the most positive code.
- R11: With suppression active, a filtered channel's keep flag is 1 if at least one of its samples in the window qualified. The flag is cleared at each window start, so earlier windows do not carry over.
- R12: The threshold of channel c is the signed field `cfg_thresh[c*SW +: SW]`, with channel 0 in the least significant bits. Bit c of every per-channel vector belongs to channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_start | input | 1 | Opens an event window (used in IDLE) |
| win_end | input | 1 | Closes the window (used in COLLECT) |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | CHW | Channel index of the sample |
| in_sample | input | SW | Signed sample |
| cfg_chan_en | input | NCH | Channel enable, bit c = channel c |
| cfg_zs_en | input | NCH | Channel takes part in digital suppression |
| cfg_polarity | input | NCH | 0 active-high, 1 active-low |
| cfg_edge | input | NCH | 0 keep above threshold, 1 keep below |
| cfg_thresh | input | NCH*SW | Packed signed thresholds, channel 0 lowest |
| cfg_mode | input | 3 | Bit 0 bypass, bit 1 unused, bit 2 digital suppression on |
| out_valid | output | 1 | Forwarded sample strobe |
| out_chan | output | CHW | Forwarded channel index |
| out_sample | output | SW | Forwarded sample |
| keep_valid | output | 1 | High for the single REPORT cycle |
| keep_flags | output | NCH | Per-channel keep decision, valid with keep_valid |

## Verification
The windows mix channels set up to separate the comparison variants. One sample equals its threshold in each direction, to expose a non-strict compare. Active-low samples are chosen so that missing negation fails, and the most negative code is placed against a threshold one below the maximum, so that wrapping instead of saturating fails. Further windows check that flags clear between windows, that a sample sent while idle is dropped, and that a disabled channel, bypass mode, global-off mode and unfiltered channels each decide the flags alone. A behavioural model runs alongside and follows the stream and the report timing in every cycle.

// File: rtl/dzs_pkg.sv
package dzs_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_REPORT  = 2'd2
    } dzs_state_e;

    localparam int MODE_W          = 3;
    localparam int MODE_BYPASS_BIT = 0;
    localparam int MODE_DIGITAL_BIT = 2;
endpackage

// File: rtl/dzs_thresh_mux.sv
module dzs_thresh_mux #(
    parameter int NCH = 8,
    parameter int SW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH*SW-1:0]   thresh_flat,
    input  logic [CHW-1:0]      sel,
    output logic signed [SW-1:0] thresh
);
    logic signed [SW-1:0] table_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign table_q[g] = thresh_flat[g*SW +: SW];
    end

    assign thresh = table_q[sel];
endmodule

// File: rtl/dzs_qualify.sv
module dzs_qualify #(
    parameter int SW = 12
) (
    input  logic signed [SW-1:0] sample,
    input  logic signed [SW-1:0] thresh,
    input  logic                 active_low,
    input  logic                 keep_below,
    output logic                 hit
);
    localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

    logic signed [SW-1:0] level;

    always_comb begin
        if (active_low) begin
            level = (sample == SMIN) ? SMAX : -sample;
        end else begin
            level = sample;
        end
        hit = keep_below ? (level < thresh) : (level > thresh);
    end
endmodule

// File: rtl/dzs_hit_bank.sv
module dzs_hit_bank #(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           set_valid,
    input  logic [CHW-1:0] set_chan,
    input  logic           set_hit,
    output logic [NCH-1:0] hits
);
    for (genvar g = 0; g < NCH; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hits[g] <= 1'b0;
            end else if (clear) begin
                hits[g] <= 1'b0;
            end else if (set_valid && set_hit && (set_chan == CHW'(g))) begin
                hits[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dzs_filter.sv
module dzs_filter
    import dzs_pkg::*;
#(
    parameter int NCH = 8,
    parameter int SW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_start,
    input  logic              win_end,
    input  logic              in_valid,
    input  logic [CHW-1:0]    in_chan,
    input  logic [SW-1:0]     in_sample,
    input  logic [NCH-1:0]    cfg_chan_en,
    input  logic [NCH-1:0]    cfg_zs_en,
    input  logic [NCH-1:0]    cfg_polarity,
    input  logic [NCH-1:0]    cfg_edge,
    input  logic [NCH*SW-1:0] cfg_thresh,
    input  logic [MODE_W-1:0] cfg_mode,
    output logic              out_valid,
    output logic [CHW-1:0]    out_chan,
    output logic [SW-1:0]     out_sample,
    output logic              keep_valid,
    output logic [NCH-1:0]    keep_flags
);
    dzs_state_e state, state_d;

    logic                 chan_on;
    logic                 accept;
    logic                 sample_hit;
    logic signed [SW-1:0] sel_thresh;
    logic [NCH-1:0]       hits;
    logic                 pass_all;
    logic                 unused_mode_bit;

    assign unused_mode_bit = cfg_mode[1];
    assign chan_on  = cfg_chan_en[in_chan];
    assign accept   = (state == S_COLLECT) && in_valid && chan_on;
    assign pass_all = cfg_mode[MODE_BYPASS_BIT] || !cfg_mode[MODE_DIGITAL_BIT];

    dzs_thresh_mux #(.NCH(NCH), .SW(SW)) u_thresh_mux (
        .thresh_flat (cfg_thresh),
        .sel         (in_chan),
        .thresh      (sel_thresh)
    );

    dzs_qualify #(.SW(SW)) u_qualify (
        .sample     (in_sample),
        .thresh     (sel_thresh),
        .active_low (cfg_polarity[in_chan]),
        .keep_below (cfg_edge[in_chan]),
        .hit        (sample_hit)
    );

    dzs_hit_bank #(.NCH(NCH)) u_hit_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     ((state == S_IDLE) && win_start),
        .set_valid (accept),
        .set_chan  (in_chan),
        .set_hit   (sample_hit),
        .hits      (hits)
    );

    // next-state logic: open, close, retire
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:    if (win_start) state_d = S_COLLECT;
            S_COLLECT: if (win_end)   state_d = S_REPORT;
            S_REPORT:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // forwarded sample stream
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_chan   <= '0;
            out_sample <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_chan   <= in_chan;
                out_sample <= in_sample;
            end
        end
    end

    // decision outputs
    always_comb begin
        keep_valid = 1'b0;
        keep_flags = '0;
        unique case (state)
            S_IDLE, S_COLLECT: begin
                keep_valid = 1'b0;
            end
            S_REPORT: begin
                keep_valid = 1'b1;
                keep_flags = cfg_chan_en & ({NCH{pass_all}} | ~cfg_zs_en | hits);
            end
            default: begin
                keep_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dzs_filter_sva.sv
module dzs_filter_sva
    import dzs_pkg::*;
#(
    parameter int NCH = 8,
    parameter int SW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input dzs_state_e        state,
    input logic              win_end,
    input logic              in_valid,
    input logic [CHW-1:0]    in_chan,
    input logic [SW-1:0]     in_sample,
    input logic [NCH-1:0]    cfg_chan_en,
    input logic [NCH-1:0]    cfg_zs_en,
    input logic [MODE_W-1:0] cfg_mode,
    input logic              out_valid,
    input logic [CHW-1:0]    out_chan,
    input logic [SW-1:0]     out_sample,
    input logic              keep_valid,
    input logic [NCH-1:0]    keep_flags
);
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!keep_valid && !out_valid));

    a_r2_close_to_report: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT && win_end) |=> keep_valid);

    a_r2_report_single: assert property (@(posedge clk) disable iff (!rst_n)
        keep_valid |=> !keep_valid);

    a_r3_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT && in_valid && cfg_chan_en[in_chan]) |=>
        (out_valid && out_chan == $past(in_chan) && out_sample == $past(in_sample)));

    a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_COLLECT) |=> !out_valid);

    a_r4_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
        keep_valid |-> ((keep_flags & ~cfg_chan_en) == '0));

    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_valid && cfg_mode[MODE_BYPASS_BIT]) |-> (keep_flags == cfg_chan_en));

    a_r7_unfiltered: assert property (@(posedge clk) disable iff (!rst_n)
        keep_valid |-> (((cfg_chan_en & ~cfg_zs_en) & ~keep_flags) == '0));
endmodule

bind dzs_filter dzs_filter_sva #(.NCH(NCH), .SW(SW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .win_end     (win_end),
    .in_valid    (in_valid),
    .in_chan     (in_chan),
    .in_sample   (in_sample),
    .cfg_chan_en (cfg_chan_en),
    .cfg_zs_en   (cfg_zs_en),
    .cfg_mode    (cfg_mode),
    .out_valid   (out_valid),
    .out_chan    (out_chan),
    .out_sample  (out_sample),
    .keep_valid  (keep_valid),
    .keep_flags  (keep_flags)
);

// File: tb/dzs_filter_tb.sv
`timescale 1ns/1ps
module dzs_filter_tb;
    localparam int NCH = 8;
    localparam int SW  = 12;
    localparam int CHW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_start = 0, win_end = 0, in_valid = 0;
    logic [CHW-1:0] in_chan = '0;
    logic signed [SW-1:0] in_sample = '0;
    logic [NCH-1:0] cfg_chan_en = '1, cfg_zs_en = '0, cfg_polarity = '0, cfg_edge = '0;
    logic [NCH*SW-1:0] cfg_thresh;
    logic [2:0] cfg_mode = 3'b100;
    logic signed [SW-1:0] th [NCH];
    logic out_valid, keep_valid;
    logic [CHW-1:0] out_chan;
    logic [SW-1:0] out_sample;
    logic [NCH-1:0] keep_flags;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) cfg_thresh[i*SW +: SW] = th[i];
    end

    dzs_filter #(.NCH(NCH), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
        .in_valid(in_valid), .in_chan(in_chan), .in_sample(in_sample),
        .cfg_chan_en(cfg_chan_en), .cfg_zs_en(cfg_zs_en), .cfg_polarity(cfg_polarity),
        .cfg_edge(cfg_edge), .cfg_thresh(cfg_thresh), .cfg_mode(cfg_mode),
        .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample),
        .keep_valid(keep_valid), .keep_flags(keep_flags)
    );

    // behavioural reference model
    int  mst = 0;
    bit  hit_m [NCH];
    bit  ex_ov = 0;
    int  ex_oc = 0;
    int  ex_os = 0;

    function automatic bit qual(int s, int t, bit lowp, bit below);
        int v = lowp ? -s : s;
        if (v > 2047) v = 2047;
        return below ? (v < t) : (v > t);
    endfunction

    function automatic logic [NCH-1:0] model_flags();
        logic [NCH-1:0] f = '0;
        for (int c = 0; c < NCH; c++) begin
            f[c] = cfg_chan_en[c] && (cfg_mode[0] || !cfg_mode[2] || !cfg_zs_en[c] || hit_m[c]);
        end
        return f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; ex_ov = 0;
            for (int c = 0; c < NCH; c++) hit_m[c] = 0;
        end else begin
            ex_ov = (mst == 1) && in_valid && cfg_chan_en[in_chan];
            ex_oc = int'(in_chan);
            ex_os = int'(in_sample);
            case (mst)
                0: if (win_start) begin
                       mst = 1;
                       for (int c = 0; c < NCH; c++) hit_m[c] = 0;
                   end
                1: begin
                       if (in_valid && cfg_chan_en[in_chan] &&
                           qual(int'(in_sample), int'(th[in_chan]), cfg_polarity[in_chan], cfg_edge[in_chan]))
                           hit_m[in_chan] = 1;
                       if (win_end) mst = 2;
                   end
                default: mst = 0;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_valid !== ex_ov) begin
                errors++;
                $display("FAIL R3 out_valid actual %0b expected %0b", out_valid, ex_ov);
            end else if (ex_ov && (int'(out_chan) != ex_oc || int'($signed(out_sample)) != ex_os)) begin
                errors++;
                $display("FAIL R3 out data actual %0d/%0d expected %0d/%0d",
                         out_chan, $signed(out_sample), ex_oc, ex_os);
            end
            checks++;
            if (keep_valid !== (mst == 2)) begin
                errors++;
                $display("FAIL R2 keep_valid actual %0b expected %0b", keep_valid, mst == 2);
            end else if (mst == 2 && keep_flags !== model_flags()) begin
                errors++;
                $display("FAIL R11 keep_flags actual %h expected %h", keep_flags, model_flags());
            end
        end
    end

    task automatic start_win();
        @(negedge clk); #1;
        win_start = 1; win_end = 0; in_valid = 0;
    endtask

    task automatic send(input int ch, input int s, input bit last);
        @(negedge clk); #1;
        win_start = 0; in_valid = 1; in_chan = CHW'(ch); in_sample = SW'(s); win_end = last;
    endtask

    task automatic end_check(input logic [NCH-1:0] exp, input string tag);
        @(negedge clk); #1;
        in_valid = 0; win_end = 0; win_start = 0;
        checks++;
        if (keep_valid !== 1'b1 || keep_flags !== exp) begin
            errors++;
            $display("FAIL %s flags actual %0b/%h expected 1/%h", tag, keep_valid, keep_flags, exp);
        end
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) th[c] = '0;
        th[0] = 100; th[1] = -50; th[2] = 200; th[3] = 2046;
        cfg_zs_en = 8'h7F;            // ch7 unfiltered
        cfg_edge = 8'h02;             // ch1 keeps below
        cfg_polarity = 8'h0C;         // ch2, ch3 active-low
        repeat (3) @(negedge clk);
        checks++;                     // R1 reset state
        if (out_valid !== 0 || keep_valid !== 0 || keep_flags !== '0) begin
            errors++;
            $display("FAIL R1 reset actual %0b/%0b/%h expected 0/0/00", out_valid, keep_valid, keep_flags);
        end
        #1 rst_n = 1;
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || keep_valid !== 0) begin
            errors++;
            $display("FAIL R1 after reset actual %0b/%0b expected 0/0", out_valid, keep_valid);
        end

        // window 1: R8 equality, R9, R10 negation and saturation, R7, R12
        start_win();
        send(0, 100, 0);   // equal, above-test: no
        send(1, -50, 0);   // equal, below-test: no
        send(2, -201, 0);  // active-low -> 201 > 200
        send(3, -2048, 0); // saturates to 2047 > 2046
        send(4, 1, 0);
        send(5, 0, 0);
        send(6, -5, 1);
        end_check(8'h9C, "R8 R9 R10 R7 R12");

        // sample while idle is dropped (R3), win_end while idle ignored (R2)
        @(negedge clk); #1; in_valid = 1; in_chan = 5; in_sample = 1000; win_end = 1;
        @(negedge clk); #1; in_valid = 0; win_end = 0;
        @(negedge clk);
        checks++;
        if (keep_valid !== 0 || out_valid !== 0) begin
            errors++;
            $display("FAIL R2 idle win_end actual %0b/%0b expected 0/0", keep_valid, out_valid);
        end

        // window 2: flags cleared (R11), strict pass (R8, R9)
        start_win();
        send(0, 101, 0);
        send(1, -51, 1);
        end_check(8'h83, "R11");

        // window 3: disabled channel and bypass (R4, R5)
        cfg_chan_en = 8'hFE; cfg_mode = 3'b101;
        start_win();
        send(0, 500, 0);
        send(5, 0, 1);
        end_check(8'hFE, "R4 R5");

        // window 4: digital suppression off, bit 1 set (R6)
        cfg_chan_en = 8'hFF; cfg_mode = 3'b010;
        start_win();
        send(5, 0, 1);
        end_check(8'hFF, "R6");

        // window 5: suppression on again, no qualifying samples (R11)
        cfg_mode = 3'b100;
        start_win();
        send(2, 199, 0);
        send(4, 0, 1);
        end_check(8'h80, "R11");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule